// File: doc/BRIEF.md
# CCD Horizontal Line Readout Sequencer

This block drives the horizontal side of a dual-output interline CCD for one line at a time. A one-cycle request starts the line. The sequencer first holds the horizontal phases and the transfer gate in a fixed parking state while the vertical register moves a row down. It then lowers the transfer gate and waits a settle window. Next it raises H1 for one alignment cycle, so that the packets in the two horizontal registers line up. After that it clocks a fixed number of pixel periods, and then returns to idle.

During each pixel period the block drives the reset gate. It also reports a pixel index and a 3-bit tag that says which physical region of the line the packet comes from. A downstream capture stage uses the tag to tell empty, dark-current, buffer, active and dark-reference samples apart. In the 4x4 binning mode, H2 skips its first low pulse of the line. This moves the summed colour groups by one column pair. The block has no data path, so every pin is a plain control or status level and there is no valid/ready handshake.

Top module: `ccd_hseq_top`

## Requirements
- R1: After reset, and whenever no line is in progress, h2 is high and h1, h3, h4, h4l, tg, rg, pix_act and line_done are low, with pix_idx 0 and region 0.
- R2: A line_start seen while idle makes tg and h2 high, with h1, h3, h4 and h4l low, for exactly XFER_CYC (default 4) cycles, starting in the cycle after the strobe.
- R3: After the transfer window, tg is low and h2 is high, with h1, h3, h4 and h4l low, for SETTLE_CYC (default 4) cycles. Then comes one alignment cycle with h1 and h2 high and h3, h4 and h4l low.
- R4: Each pixel period is two clocks. In phase A, h3, h4 and h4l are high and h1 and h2 are low. In phase B, h1 and h2 are high and h3, h4 and h4l are low. A line has exactly 1938 pixel periods, and they start right after the alignment cycle.
- R5: rg is high in phase A of every pixel period and low at all other times. The reset therefore comes after phase B, where the previous packet was sampled, and before the next h4l fall.
- R6: pix_act is high during every pixel period. pix_idx counts 0 to 1937, holds its value for both clocks of a period, and increases by one from each period to the next.
- R7: region is a function of pix_idx, coded 0 empty, 1 dark-current, 2 buffer, 3 active, 4 dark dummy, 5 dark reference. The indices map as follows: 0-3 give 0, 4-5 give 1, 6-9 give 2, 10-1889 give 3, 1890-1893 give 2, 1894 gives 4, 1895-1931 give 5, and 1932-1937 give 4.
- R8: bin_mode is a 2-bit select (0 full, 1 1x2, 2 2x2, 3 4x4) that is captured with line_start. When the captured value is 3, h2 stays high during phase A of pixel period 0. Every other value, and every other period, follows R4. A change of bin_mode during a line has no effect on that line.
- R9: line_done is high for exactly one cycle, the cycle after phase B of pixel period 1937. The block is idle in the cycle after that.
- R10: A line_start that arrives while a line is in progress, including the line_done cycle, is ignored. The running line's outputs do not change, and no new line follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_start | input | 1 | One-cycle request to read a line |
| bin_mode | input | 2 | Binning select, captured at line start |
| h1 | output | 1 | Horizontal phase 1 enable |
| h2 | output | 1 | Horizontal phase 2 enable |
| h3 | output | 1 | Horizontal phase 3 enable |
| h4 | output | 1 | Horizontal phase 4 enable |
| h4l | output | 1 | Last-gate phase 4 enable (fall dumps a packet) |
| tg | output | 1 | Vertical-to-horizontal transfer gate |
| rg | output | 1 | Sense-node reset gate |
| pix_act | output | 1 | High during the pixel periods of a line |
| region | output | 3 | Region tag of the current pixel period |
| pix_idx | output | 11 | Index of the current pixel period |
| line_done | output | 1 | One-cycle end-of-line strobe |

## Verification
The bench compares every pin on every cycle of each line with a model of the whole line. The model has a separate region lookup, which catches a map that is one index off at any of the seven region boundaries (for example at 9/10 or 1931/1932), and a line that is one period too long or too short. Lines in mode 3 check the H2 skip, and other lines check that it is absent. The bench toggles bin_mode in the middle of a line, so a design that reads the mode live rather than capturing it at line start skips or adds an H2 pulse. Stray line_start pulses in the middle of a line and on the line_done cycle would restart the transfer gate or chain a second line in a design that does not ignore them. The fixed parking windows around tg show whether h1 rises too early or the settle count is off by one.

// File: rtl/ccd_hseq_pkg.sv
package ccd_hseq_pkg;

  typedef enum logic [2:0] {
    TAG_EMPTY = 3'd0,
    TAG_DARKI = 3'd1,
    TAG_BUF   = 3'd2,
    TAG_ACT   = 3'd3,
    TAG_DDUM  = 3'd4,
    TAG_DREF  = 3'd5
  } tag_t;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_XFER   = 3'd1,
    ST_SETTLE = 3'd2,
    ST_ALIGN  = 3'd3,
    ST_RUN    = 3'd4,
    ST_DONE   = 3'd5
  } seq_state_t;

  localparam logic [1:0] MODE_BIN4X4 = 2'd3;

endpackage

// File: rtl/ccd_hseq_region.sv
module ccd_hseq_region
  import ccd_hseq_pkg::*;
#(
  parameter int N_EMPTY = 4,
  parameter int N_DARKI = 2,
  parameter int N_BUF   = 4,
  parameter int N_ACT   = 1880,
  parameter int N_DDUM1 = 1,
  parameter int N_DREF  = 37,
  parameter int N_DDUM2 = 6,
  parameter int PW      = 11
) (
  input  logic [PW-1:0] idx,
  output tag_t          tag
);
  // exclusive upper bounds of each span, in line order
  localparam int E0 = N_EMPTY;
  localparam int E1 = E0 + N_DARKI;
  localparam int E2 = E1 + N_BUF;
  localparam int E3 = E2 + N_ACT;
  localparam int E4 = E3 + N_BUF;
  localparam int E5 = E4 + N_DDUM1;
  localparam int E6 = E5 + N_DREF;

  localparam logic [PW-1:0] B0 = PW'(E0);
  localparam logic [PW-1:0] B1 = PW'(E1);
  localparam logic [PW-1:0] B2 = PW'(E2);
  localparam logic [PW-1:0] B3 = PW'(E3);
  localparam logic [PW-1:0] B4 = PW'(E4);
  localparam logic [PW-1:0] B5 = PW'(E5);
  localparam logic [PW-1:0] B6 = PW'(E6);

  always_comb begin
    if      (idx < B0) tag = TAG_EMPTY;
    else if (idx < B1) tag = TAG_DARKI;
    else if (idx < B2) tag = TAG_BUF;
    else if (idx < B3) tag = TAG_ACT;
    else if (idx < B4) tag = TAG_BUF;
    else if (idx < B5) tag = TAG_DDUM;
    else if (idx < B6) tag = TAG_DREF;
    else               tag = TAG_DDUM;
  end
endmodule

// File: rtl/ccd_hseq_ctrl.sv
module ccd_hseq_ctrl
  import ccd_hseq_pkg::*;
#(
  parameter int XFER_CYC   = 4,
  parameter int SETTLE_CYC = 4,
  parameter int LINE_LEN   = 1938,
  parameter int PW         = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    mode_in,
  output seq_state_t    state,
  output logic          sub,
  output logic [PW-1:0] pix,
  output logic [1:0]    mode_q
);
  localparam int CMAX = (XFER_CYC > SETTLE_CYC) ? XFER_CYC : SETTLE_CYC;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [PW-1:0] LAST = PW'(LINE_LEN - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      sub    <= 1'b0;
      pix    <= '0;
      mode_q <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state  <= ST_XFER;
          cnt    <= CW'(XFER_CYC - 1);
          mode_q <= mode_in;
        end
        ST_XFER: if (cnt == '0) begin
          state <= ST_SETTLE;
          cnt   <= CW'(SETTLE_CYC - 1);
        end else begin
          cnt <= cnt - 1'b1;
        end
        ST_SETTLE: if (cnt == '0) state <= ST_ALIGN;
                   else           cnt   <= cnt - 1'b1;
        ST_ALIGN: begin
          state <= ST_RUN;
          sub   <= 1'b0;
          pix   <= '0;
        end
        ST_RUN: begin
          sub <= ~sub;
          if (sub) begin
            if (pix == LAST) begin
              state <= ST_DONE;
              pix   <= '0;
            end else begin
              pix <= pix + 1'b1;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_hseq_phase.sv
module ccd_hseq_phase
  import ccd_hseq_pkg::*;
(
  input  seq_state_t state,
  input  logic       sub,
  input  logic       first_pix,
  input  logic       skip_en,
  output logic       h1,
  output logic       h2,
  output logic       h3,
  output logic       h4,
  output logic       h4l,
  output logic       tg,
  output logic       rg
);
  always_comb begin
    h1 = 1'b0; h2 = 1'b1; h3 = 1'b0; h4 = 1'b0; h4l = 1'b0;
    tg = 1'b0; rg = 1'b0;
    case (state)
      ST_XFER:  tg = 1'b1;
      ST_ALIGN: h1 = 1'b1;
      ST_RUN: begin
        if (!sub) begin
          h1  = 1'b0;
          h2  = skip_en && first_pix;
          h3  = 1'b1;
          h4  = 1'b1;
          h4l = 1'b1;
          rg  = 1'b1;
        end else begin
          h1 = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ccd_hseq_top.sv
module ccd_hseq_top
  import ccd_hseq_pkg::*;
#(
  parameter int XFER_CYC   = 4,
  parameter int SETTLE_CYC = 4,
  parameter int N_EMPTY    = 4,
  parameter int N_DARKI    = 2,
  parameter int N_BUF      = 4,
  parameter int N_ACT      = 1880,
  parameter int N_DDUM1    = 1,
  parameter int N_DREF     = 37,
  parameter int N_DDUM2    = 6,
  localparam int LINE_LEN  = N_EMPTY + N_DARKI + 2*N_BUF + N_ACT + N_DDUM1 + N_DREF + N_DDUM2,
  localparam int PW        = $clog2(LINE_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_start,
  input  logic [1:0]    bin_mode,
  output logic          h1,
  output logic          h2,
  output logic          h3,
  output logic          h4,
  output logic          h4l,
  output logic          tg,
  output logic          rg,
  output logic          pix_act,
  output logic [2:0]    region,
  output logic [PW-1:0] pix_idx,
  output logic          line_done
);
  seq_state_t    state;
  logic          sub;
  logic [PW-1:0] pix;
  logic [1:0]    mode_q;
  tag_t          tag;

  ccd_hseq_ctrl #(
    .XFER_CYC(XFER_CYC), .SETTLE_CYC(SETTLE_CYC), .LINE_LEN(LINE_LEN), .PW(PW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(line_start), .mode_in(bin_mode),
    .state(state), .sub(sub), .pix(pix), .mode_q(mode_q)
  );

  ccd_hseq_phase u_phase (
    .state(state), .sub(sub), .first_pix(pix == '0),
    .skip_en(mode_q == MODE_BIN4X4),
    .h1(h1), .h2(h2), .h3(h3), .h4(h4), .h4l(h4l), .tg(tg), .rg(rg)
  );

  ccd_hseq_region #(
    .N_EMPTY(N_EMPTY), .N_DARKI(N_DARKI), .N_BUF(N_BUF), .N_ACT(N_ACT),
    .N_DDUM1(N_DDUM1), .N_DREF(N_DREF), .N_DDUM2(N_DDUM2), .PW(PW)
  ) u_region (
    .idx(pix), .tag(tag)
  );

  assign pix_act   = (state == ST_RUN);
  assign pix_idx   = pix;
  assign region    = tag;
  assign line_done = (state == ST_DONE);
endmodule

// File: rtl/ccd_hseq_chk.sv
module ccd_hseq_chk #(
  parameter int PW = 11
) (
  input logic          clk,
  input logic          rst_n,
  input logic          h1,
  input logic          h2,
  input logic          h3,
  input logic          h4,
  input logic          h4l,
  input logic          tg,
  input logic          rg,
  input logic          pix_act,
  input logic [2:0]    region,
  input logic [PW-1:0] pix_idx,
  input logic          line_done
);
  p_park_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tg |-> (h2 && !h1 && !h3 && !h4 && !h4l));

  p_tg_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tg) |-> (!h1 && !h3 && !h4l));

  p_compl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_act |-> ((h3 == h4) && (h4l == h4) && (h1 != h3)));

  p_rg_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rg |-> (pix_act && h4l));

  p_idx_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_act && $past(pix_act) && h3) |-> (pix_idx == $past(pix_idx) + 1'b1));

  p_first_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_act && pix_idx == '0) |-> (region == 3'd0));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> !line_done);

  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_done |=> (!tg && !pix_act));
endmodule

bind ccd_hseq_top ccd_hseq_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst_n(rst_n), .h1(h1), .h2(h2), .h3(h3), .h4(h4), .h4l(h4l),
  .tg(tg), .rg(rg), .pix_act(pix_act), .region(region), .pix_idx(pix_idx),
  .line_done(line_done)
);

// File: tb/ccd_hseq_top_bench.sv
module ccd_hseq_top_bench;
  localparam int X = 4;
  localparam int S = 4;
  localparam int L = 1938;
  localparam int TOTAL = X + S + 1 + 2*L + 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [1:0] bin_mode = 2'd0;
  logic h1, h2, h3, h4, h4l, tg, rg, pix_act, line_done;
  logic [2:0] region;
  logic [10:0] pix_idx;

  int checks = 0;
  int bad = 0;

  always #2 clk = ~clk;

  ccd_hseq_top u_ccd_hseq_top (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .bin_mode(bin_mode),
    .h1(h1), .h2(h2), .h3(h3), .h4(h4), .h4l(h4l), .tg(tg), .rg(rg),
    .pix_act(pix_act), .region(region), .pix_idx(pix_idx), .line_done(line_done)
  );

  typedef struct packed {
    logic [6:0]  ph;   // h1 h2 h3 h4 h4l tg rg
    logic        act;
    logic [2:0]  reg_t;
    logic [10:0] idx;
    logic        done;
  } exp_t;

  function automatic logic [2:0] ref_region(int p);
    if (p <= 3)    return 3'd0;
    if (p <= 5)    return 3'd1;
    if (p <= 9)    return 3'd2;
    if (p <= 1889) return 3'd3;
    if (p <= 1893) return 3'd2;
    if (p == 1894) return 3'd4;
    if (p <= 1931) return 3'd5;
    return 3'd4;
  endfunction

  // k counts cycles after the clock edge that took line_start
  function automatic exp_t ref_out(int k, logic [1:0] m);
    exp_t e;
    e = '0;
    e.ph = 7'b0100000;
    if (k >= 1 && k <= X) e.ph = 7'b0100010;
    else if (k == X + S + 1) e.ph = 7'b1100000;
    else if (k >= X + S + 2 && k < X + S + 2 + 2*L) begin
      int j, p;
      j = k - (X + S + 2);
      p = j / 2;
      e.act = 1'b1;
      e.idx = 11'(p);
      e.reg_t = ref_region(p);
      if (j % 2 == 0) e.ph = {1'b0, (m == 2'd3 && p == 0), 5'b11101};
      else            e.ph = 7'b1100000;
    end else if (k == TOTAL) e.done = 1'b1;
    return e;
  endfunction

  function automatic string tag_for(int k, logic [1:0] m);
    int j;
    if (k <= 0 || k > TOTAL) return "R1";
    if (k <= X) return "R2";
    if (k <= X + S + 1) return "R3";
    if (k == TOTAL) return "R9";
    j = k - (X + S + 2);
    if (m == 2'd3 && j == 0) return "R8";
    return "R4";
  endfunction

  task automatic cmp(string tag, string what, int got, int want);
    checks++;
    if (got != want) begin
      bad++;
      $display("FAIL %s %s got=%0d expected=%0d at %0t", tag, what, got, want, $time);
    end
  endtask

  task automatic check_all(int k, logic [1:0] m, string ctx);
    exp_t e;
    e = ref_out(k, m);
    cmp({tag_for(k, m), ctx}, "phases h1h2h3h4h4l,tg", int'({h1, h2, h3, h4, h4l, tg}), int'(e.ph[6:1]));
    cmp({"R5", ctx}, "rg", int'(rg), int'(e.ph[0]));
    cmp({"R6", ctx}, "pix_act", int'(pix_act), int'(e.act));
    cmp({"R6", ctx}, "pix_idx", int'(pix_idx), int'(e.idx));
    cmp({"R7", ctx}, "region", int'(region), int'(e.reg_t));
    cmp({"R9", ctx}, "line_done", int'(line_done), int'(e.done));
  endtask

  // strays: 1 puts extra line_start pulses and mode toggles into the line
  task automatic run_line(logic [1:0] m, bit strays);
    int stray_k;
    stray_k = 20 + int'($urandom_range(0, 3000));
    line_start = 1'b1;
    bin_mode = m;
    @(negedge clk);
    line_start = 1'b0;
    for (int k = 1; k <= TOTAL + 2; k++) begin
      check_all(k, m, strays ? " R10 stray" : "");
      line_start = 1'b0;
      if (strays) begin
        bin_mode = 2'($urandom_range(0, 3));
        if (k == stray_k || k == 3 || k == X + S + 2 || k == TOTAL) line_start = 1'b1;
      end
      @(negedge clk);
    end
    line_start = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_all(0, 2'd0, " reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all(0, 2'd0, " idle");
    run_line(2'd3, 1'b0);          // R8 skip present
    run_line(2'd0, 1'b0);          // normal spacing, back to back
    run_line(2'd3, 1'b1);          // R8 mode held while bin_mode toggles, R10 strays
    for (int n = 0; n < 3; n++) begin
      repeat ($urandom_range(0, 5)) begin
        check_all(0, 2'd0, " gap");
        @(negedge clk);
      end
      run_line(2'($urandom_range(0, 3)), 1'b1);
    end
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule